// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block turns one host request into one programmed-I/O register access on an ATA bus. A request carries a target device number, a register address, a direction and, for a write, a data word. The block sequences the bus through the address setup, strobe, hold and recovery phases. It drives the register address, the two active-low chip selects, the active-low read and write strobes, and the data-bus output enable. It waits on the device's IORDY line when told to, and it returns the word read.

Phase lengths come from 32-bit timing words. Each word packs four 8-bit fields, and a phase lasts its field value plus one clock. There is one shared command word and one fast word per device. The block picks one per request from the target device's fast-timing enable. Each of these words has its own IORDY enable. A core enable gates acceptance of new requests. A separate bus-reset request drives the ATA reset line directly.

The state machine has seven states. IDLE moves to SETUP on acceptance. SETUP moves to STROBE when the T1 count runs out. STROBE moves to HOLD when the T2 count runs out, or to STALL instead if IORDY waiting is enabled and the synchronised IORDY is low. STALL moves to HOLD once the synchronised IORDY goes high. HOLD moves to FINISH when the T4 count runs out. FINISH moves to RECOVER after one clock. RECOVER moves back to IDLE when the Teoc count runs out.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset both strobes are high, `ata_cs_n` is 2'b11, `ata_dd_oe` and `busy` are low, and `req_ready` equals `core_en`.
- R2: On acceptance the timing word is chosen as follows. If `fast_en[req_dev]` is 1, the word is `fast_timing[req_dev]`; otherwise it is `cmd_timing`. The field layout is T1 in bits 7:0, T2 in bits 15:8, T4 in bits 23:16 and Teoc in bits 31:24.
- R3: For T1+1 clocks after acceptance, both strobes stay high while the address is driven. `ata_da` equals `req_addr[2:0]`. `ata_cs_n` is 2'b10 when `req_addr[3]`=0 and 2'b01 when `req_addr[3]`=1. Address and chip selects stay stable until the end of the hold phase.
- R4: Without a stall, the strobe is low for exactly T2+1 clocks. A read drives only `ata_dior_n` low and a write drives only `ata_diow_n` low.
- R5: After the strobe rises, address and chip selects remain for T4+1 clocks. One further clock follows with the bus idle, so an unstalled access lasts (T1+1)+(T2+1)+(T4+1)+1 clocks.
- R6: After the access, `busy` stays high for Teoc+1 recovery clocks. `busy` is high from the clock after acceptance through the end of recovery, and `req_ready` is low whenever `busy` is high.
- R7: On a write, `ata_dd_oe` is high and `ata_dd_out` equals the request's write data from the first setup clock to the last hold clock. On a read, `ata_dd_oe` stays low.
- R8: On a read, `rd_data` takes `ata_dd_in` at the clock edge where `ata_dior_n` rises. `rd_valid` is high for exactly the one clock that follows. A write produces no `rd_valid`.
- R9: IORDY passes through a two-flop synchroniser. If the applicable IORDY enable is set and the synchronised IORDY is low when T2 ends, the strobe stays low until the synchronised IORDY is high. If IORDY is raised after S strobe clocks, the strobe width is max(T2+1, S+2).
- R10: The applicable IORDY enable is `rdy_en_cmd` for the command word and `rdy_en_fast[d]` for device d's fast word. The other IORDY enables have no effect on the access.
- R11: While `core_en` is low, `req_ready` is low, no request is accepted, and the bus stays idle.
- R12: `ata_rst_n` is the inverse of `bus_rst_req` at all times, independent of clock and core enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Allows new requests to be accepted |
| bus_rst_req | input | 1 | Requests assertion of the ATA bus reset |
| fast_en | input | NDEV | Per-device fast timing select |
| rdy_en_cmd | input | 1 | IORDY wait enable for the command word |
| rdy_en_fast | input | NDEV | IORDY wait enable for each fast word |
| cmd_timing | input | 32 | Shared command timing word |
| fast_timing | input | NDEV x 32 | Per-device fast timing words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | DEV_W | Target device number |
| req_addr | input | ADDR_W | Bit 3 selects chip select, bits 2:0 register address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-clock pulse when rd_data is new |
| busy | output | 1 | Access or recovery in progress |
| ata_rst_n | output | 1 | ATA bus reset, active low |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | ADDR_W-1 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready, asynchronous |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_out | output | DATA_W | Data bus outbound value |
| ata_dd_in | input | DATA_W | Data bus inbound value |

## Verification
The assertions take for granted that every input except `ata_iordy` is synchronous to `clk`, and that timing words and enables matter only on the acceptance clock, where they are latched. The bench changes every input on the falling edge, and it moves `ata_iordy` only while a strobe is being counted. That way the two-flop latency lands on a known rising edge. The bench sweeps all T1, T2 and T4 values from 0 to 2 and Teoc values 0 and 1, across every device and timing-select combination. The timing words that are not selected hold out-of-range values, so a wrong selection shows up at once as a wrong phase length.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_STALL,
        ST_HOLD,
        ST_FINISH,
        ST_RECOVER
    } pio_state_e;

    // Packed MSB first: recovery, hold, pulse, setup
    typedef struct packed {
        logic [FIELD_W-1:0] teoc;
        logic [FIELD_W-1:0] t4;
        logic [FIELD_W-1:0] t2;
        logic [FIELD_W-1:0] t1;
    } pio_timing_t;

endpackage

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_seq_pkg::*;
#(
    parameter int NDEV  = 2,
    parameter int DEV_W = $clog2(NDEV)
) (
    input  logic [31:0]            cmd_word,
    input  logic [NDEV-1:0][31:0]  fast_words,
    input  logic [NDEV-1:0]        fast_en,
    input  logic                   rdy_en_cmd,
    input  logic [NDEV-1:0]        rdy_en_fast,
    input  logic [DEV_W-1:0]       dev,
    output pio_timing_t            timing,
    output logic                   rdy_en
);
    always_comb begin
        if (fast_en[dev]) begin
            timing = pio_timing_t'(fast_words[dev]);
            rdy_en = rdy_en_fast[dev];
        end else begin
            timing = pio_timing_t'(cmd_word);
            rdy_en = rdy_en_cmd;
        end
    end
endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == '0 && !$past(load)) |-> cnt == '0);
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int NDEV        = 2,
    parameter int DEV_W       = $clog2(NDEV),
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   core_en,
    input  logic                   bus_rst_req,
    input  logic [NDEV-1:0]        fast_en,
    input  logic                   rdy_en_cmd,
    input  logic [NDEV-1:0]        rdy_en_fast,
    input  logic [31:0]            cmd_timing,
    input  logic [NDEV-1:0][31:0]  fast_timing,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [DEV_W-1:0]       req_dev,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_valid,
    output logic                   busy,
    output logic                   ata_rst_n,
    output logic [1:0]             ata_cs_n,
    output logic [ADDR_W-2:0]      ata_da,
    output logic                   ata_dior_n,
    output logic                   ata_diow_n,
    input  logic                   ata_iordy,
    output logic                   ata_dd_oe,
    output logic [DATA_W-1:0]      ata_dd_out,
    input  logic [DATA_W-1:0]      ata_dd_in
);
    localparam int DA_W = ADDR_W - 1;

    pio_state_e   st, st_nxt;
    pio_timing_t  sel_t, tq;
    logic         sel_rdy, rdy_q;
    logic         write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic         iordy_s, ph_zero, ph_load, accept, in_strobe, addr_phase;
    logic [FIELD_W-1:0] ph_val;

    pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ata_iordy), .sync_out(iordy_s)
    );

    pio_timing_sel #(.NDEV(NDEV), .DEV_W(DEV_W)) u_sel (
        .cmd_word(cmd_timing), .fast_words(fast_timing), .fast_en(fast_en),
        .rdy_en_cmd(rdy_en_cmd), .rdy_en_fast(rdy_en_fast), .dev(req_dev),
        .timing(sel_t), .rdy_en(sel_rdy)
    );

    pio_phase_ctr #(.W(FIELD_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    assign accept = req_valid && req_ready;

    // Next state and phase-counter loading
    always_comb begin
        st_nxt  = st;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (st)
            ST_IDLE: if (accept) begin
                st_nxt = ST_SETUP; ph_load = 1'b1; ph_val = sel_t.t1;
            end
            ST_SETUP: if (ph_zero) begin
                st_nxt = ST_STROBE; ph_load = 1'b1; ph_val = tq.t2;
            end
            ST_STROBE: if (ph_zero) begin
                if (rdy_q && !iordy_s) st_nxt = ST_STALL;
                else begin st_nxt = ST_HOLD; ph_load = 1'b1; ph_val = tq.t4; end
            end
            ST_STALL: if (iordy_s) begin
                st_nxt = ST_HOLD; ph_load = 1'b1; ph_val = tq.t4;
            end
            ST_HOLD: if (ph_zero) st_nxt = ST_FINISH;
            ST_FINISH: begin
                st_nxt = ST_RECOVER; ph_load = 1'b1; ph_val = tq.teoc;
            end
            ST_RECOVER: if (ph_zero) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register, request latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            tq       <= '0;
            rdy_q    <= 1'b0;
            write_q  <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            st       <= st_nxt;
            rd_valid <= 1'b0;
            if (accept) begin
                tq      <= sel_t;
                rdy_q   <= sel_rdy;
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (in_strobe && st_nxt == ST_HOLD && !write_q) begin
                rd_data  <= ata_dd_in;
                rd_valid <= 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        in_strobe  = (st == ST_STROBE) || (st == ST_STALL);
        addr_phase = (st == ST_SETUP) || in_strobe || (st == ST_HOLD);
        ata_dior_n = !(in_strobe && !write_q);
        ata_diow_n = !(in_strobe && write_q);
        ata_cs_n   = addr_phase ? (addr_q[ADDR_W-1] ? 2'b01 : 2'b10) : 2'b11;
        ata_da     = addr_phase ? addr_q[DA_W-1:0] : '0;
        ata_dd_oe  = addr_phase && write_q;
        ata_dd_out = wdata_q;
        busy       = (st != ST_IDLE);
        req_ready  = (st == ST_IDLE) && core_en;
        ata_rst_n  = !bus_rst_req;
    end

    a_r6_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));
    a_r11_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_en && st == ST_IDLE) |=> st == ST_IDLE);
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_cs_n != 2'b11 && $past(ata_cs_n) != 2'b11) |-> ($stable(ata_da) && $stable(ata_cs_n)));
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ata_dior_n, ~ata_diow_n}) <= 1);
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_dior_n |-> !ata_dd_oe);
    a_r8_capture_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!ata_dior_n) && ata_dior_n));
    a_r9_stall_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL && !iordy_s) |=> st == ST_STALL);
    a_r10_stall_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL) |-> rdy_q);
endmodule

// File: tb/pio_cycle_seq_bench.sv
`timescale 1ns/1ps
module pio_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_en = 1'b1, bus_rst_req = 1'b0;
    logic [1:0]  fast_en = '0, rdy_en_fast = '0;
    logic        rdy_en_cmd = 1'b0;
    logic [31:0] cmd_timing = '0;
    logic [1:0][31:0] fast_timing = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [0:0]  req_dev = '0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0, ata_dd_in = '0;
    logic        req_ready, rd_valid, busy, ata_rst_n, ata_dior_n, ata_diow_n, ata_dd_oe;
    logic        ata_iordy = 1'b1;
    logic [15:0] rd_data, ata_dd_out;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;

    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    pio_cycle_seq u_pio_cycle_seq (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .bus_rst_req(bus_rst_req),
        .fast_en(fast_en), .rdy_en_cmd(rdy_en_cmd), .rdy_en_fast(rdy_en_fast),
        .cmd_timing(cmd_timing), .fast_timing(fast_timing),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .ata_rst_n(ata_rst_n),
        .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
        .ata_diow_n(ata_diow_n), .ata_iordy(ata_iordy), .ata_dd_oe(ata_dd_oe),
        .ata_dd_out(ata_dd_out), .ata_dd_in(ata_dd_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    function automatic logic [31:0] mkword(input int t1, input int t2, input int t4, input int te);
        return {8'(te), 8'(t4), 8'(t2), 8'(t1)};
    endfunction

    // One access; s_raise>0 holds IORDY low until that many strobe clocks
    task automatic run_cycle(input bit wr, input int dev, input logic [3:0] addr,
                             input logic [15:0] wd, input int t1, input int t2,
                             input int t4, input int te, input int s_raise,
                             input bit stall_on, input string tag);
        int w, n_setup = 0, n_strobe = 0, n_hold = 0, n_busy = 0, n_oe = 0;
        int n_rv = 0, bad_rdy = 0, bad_addr = 0, bad_dout = 0, bad_dir = 0;
        logic [1:0] exp_cs;
        w = t2 + 1;
        if (stall_on && (s_raise + 2) > w) w = s_raise + 2;
        exp_cs = addr[3] ? 2'b01 : 2'b10;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dev = dev[0]; req_addr = addr;
        req_wdata = wd; ata_dd_in = ~wd;
        if (s_raise > 0) ata_iordy = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) begin
            n_busy++;
            if (req_ready) bad_rdy++;
            if (rd_valid) n_rv++;
            if (ata_dd_oe) begin
                n_oe++;
                if (ata_dd_out != wd) bad_dout++;
            end
            if (!ata_dior_n || !ata_diow_n) begin
                n_strobe++;
                if ((wr && !ata_dior_n) || (!wr && !ata_diow_n)) bad_dir++;
                if (s_raise > 0 && n_strobe == s_raise) ata_iordy = 1'b1;
            end else if (ata_cs_n != 2'b11) begin
                if (n_strobe == 0) n_setup++; else n_hold++;
            end
            if (ata_cs_n != 2'b11 && (ata_cs_n != exp_cs || ata_da != addr[2:0])) bad_addr++;
            @(negedge clk);
        end
        ata_iordy = 1'b1;
        chk(n_setup == t1 + 1, {tag, " R3 setup clocks"}, n_setup, t1 + 1);
        chk(bad_addr == 0, {tag, " R3 address/cs"}, bad_addr, 0);
        chk(n_strobe == w, {tag, " R4 R9 strobe width"}, n_strobe, w);
        chk(bad_dir == 0, {tag, " R4 strobe direction"}, bad_dir, 0);
        chk(n_hold == t4 + 1, {tag, " R5 hold clocks"}, n_hold, t4 + 1);
        chk(n_busy == (t1 + 1) + w + (t4 + 1) + 1 + (te + 1), {tag, " R5 R6 busy clocks"},
            n_busy, (t1 + 1) + w + (t4 + 1) + 1 + (te + 1));
        chk(bad_rdy == 0, {tag, " R6 ready low while busy"}, bad_rdy, 0);
        chk(n_oe == (wr ? (t1 + 1) + w + (t4 + 1) : 0) && bad_dout == 0,
            {tag, " R7 drive window"}, n_oe, wr ? (t1 + 1) + w + (t4 + 1) : 0);
        if (wr) chk(n_rv == 0, {tag, " R8 no rd_valid on write"}, n_rv, 0);
        else begin
            chk(n_rv == 1, {tag, " R8 rd_valid pulse"}, n_rv, 1);
            chk(rd_data == ~wd, {tag, " R8 read data"}, int'(rd_data), int'(~wd));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(busy == 0 && ata_dior_n && ata_diow_n && ata_cs_n == 2'b11 && !ata_dd_oe,
            "R1 outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && busy == 0, "R1 idle after reset", int'(req_ready), 1);

        // R12 bus reset pass-through
        bus_rst_req = 1'b1; #1;
        chk(ata_rst_n == 1'b0, "R12 reset asserted", int'(ata_rst_n), 0);
        bus_rst_req = 1'b0; #1;
        chk(ata_rst_n == 1'b1, "R12 reset released", int'(ata_rst_n), 1);

        // R11 disabled core ignores a request
        @(negedge clk);
        core_en = 1'b0; req_valid = 1'b1;
        begin
            int bad = 0;
            repeat (6) begin
                @(negedge clk);
                if (req_ready || busy || ata_cs_n != 2'b11 || !ata_dior_n) bad++;
            end
            chk(bad == 0, "R11 disabled holds off request", bad, 0);
        end
        req_valid = 1'b0; core_en = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 R11 ready returns", int'(req_ready), 1);

        // R2..R8 sweep over small fields and every selection
        for (int idx = 0; idx < 54; idx++) begin
            int t1 = idx % 3, t2 = (idx / 3) % 3, t4 = (idx / 9) % 3, te = idx / 27;
            int dev = idx % 2;
            bit fast = ((idx / 2) % 2) == 1;
            bit other = ((idx / 4) % 2) == 1;
            logic [31:0] word = mkword(t1, t2, t4, te);
            logic [31:0] junk = mkword(5, 4, 6, 3);
            fast_en = '0;
            fast_en[dev] = fast;
            fast_en[1 - dev] = other;
            cmd_timing = fast ? junk : word;
            fast_timing[dev] = fast ? word : junk;
            fast_timing[1 - dev] = junk;
            run_cycle(((idx / 3) % 2) == 1, dev, 4'(idx), 16'hA5C3 ^ 16'(idx * 257),
                      t1, t2, t4, te, 0, 1'b0, "R2 sweep");
        end

        // R9 command set with IORDY wait, long stall
        fast_en = '0; rdy_en_cmd = 1'b1; rdy_en_fast = '0;
        cmd_timing = mkword(1, 1, 0, 1);
        run_cycle(1'b0, 0, 4'h9, 16'h1234, 1, 1, 0, 1, 5, 1'b1, "R9 cmd stall");
        // R9 IORDY returns before T2 ends, no extension
        cmd_timing = mkword(0, 3, 1, 0);
        run_cycle(1'b1, 1, 4'h2, 16'h0F0F, 0, 3, 1, 0, 1, 1'b1, "R9 early ready");
        // R10 fast set of device 1 without its own enable: no stall
        fast_en = 2'b10; rdy_en_cmd = 1'b1; rdy_en_fast = 2'b01;
        fast_timing[1] = mkword(2, 0, 1, 0);
        run_cycle(1'b0, 1, 4'hE, 16'h5A5A, 2, 0, 1, 0, 6, 1'b0, "R10 other enables");
        // R10 fast set of device 1 with its enable: stall
        rdy_en_cmd = 1'b0; rdy_en_fast = 2'b10;
        run_cycle(1'b1, 1, 4'h3, 16'hC0DE, 2, 0, 1, 0, 4, 1'b1, "R10 own enable");
        // R10 command word with only fast enables set: no stall
        fast_en = 2'b00; rdy_en_fast = 2'b11; rdy_en_cmd = 1'b0;
        cmd_timing = mkword(0, 1, 0, 0);
        run_cycle(1'b0, 0, 4'h1, 16'h7777, 0, 1, 0, 0, 5, 1'b0, "R10 cmd no enable");

        finish_run();
    end
endmodule